// File: doc/BRIEF.md
# Hard-Disk Controller Host-Port Sequencer

This block is the device side of a byte-wide host port on a small hard-disk controller. The host sees four byte ports. Port 0 carries data. Port 1 reads back the bus status and resets the sequencer when written. A write to port 2 selects the controller. Port 3 holds the DMA and interrupt enables.

The sequencer steps through selection, a six-byte command block, an optional data phase in either direction and a one-byte completion phase. The host follows the handshake by reading the phase bits in the status byte. The block keeps the last error code for a later sense command and holds the drive parameters sent by the specify command. A one-sector buffer stands in for the disk media, so reads return what was last written.

Data bytes can be moved by programmed access on port 0 or, when enabled, by a request/acknowledge pair that paces the transfer one byte at a time. A completion interrupt can be raised on entry to the completion phase.

Top module: `hdc_host_seq`

## Requirements
- R1: The status byte (port 1) is laid out as bit0 REQ, bit1 I/O (device drives the byte), bit2 C/D, bit3 BUSY, bit4 DRQ, bit5 IRQ, bits 7:6 zero. It reads 0x00 after reset.
- R2: A write of any value to port 2 while idle starts a transaction. On the next cycle the status is 0x0D (command phase: BUSY, C/D, REQ).
- R3: The command block is exactly six bytes written to port 0: opcode, drive/head (drive in bit5), sector (cylinder bits 9:8 in bits 7:6, sector number in bits 5:0), cylinder low, block count, control. The phase chosen after the sixth byte depends on the opcode.
- R4: After each byte moved in any phase, REQ is low for exactly one cycle and then returns high while the phase continues.
- R5: The data-in phase reads 0x0B (BUSY, I/O, REQ). The data-out phase reads 0x09 (BUSY, REQ).
- R6: The completion phase reads 0x0F. Its single byte on port 0 has bit1 set on error and bit5 equal to the drive bit of the command. All other bits are zero.
- R7: Reading the completion byte returns the status to 0x00 on the next cycle.
- R8: Sense (0x03) returns four bytes. The first is the error code of the previous command (0x00 if it succeeded) and the other three are zero. Sense completes without error and leaves the last error code at 0x00.
- R9: Any opcode other than 0x01, 0x03, 0x08, 0x0A, 0x0C and 0x0D goes straight to the completion phase with the error bit set and records error code 0x20.
- R10: Specify (0x0C) takes eight data-out bytes. ECC-length (0x0D) then returns one byte equal to the eighth specify byte.
- R11: Write (0x0A) with count N accepts N×512 bytes into the sector buffer, and the last sector written is kept. Read (0x08) with count N returns the buffer N times. A count of 0 goes straight to completion. A sector number of 17 or more fails with error code 0x21 and has no data phase. Recalibrate (0x01) completes without error.
- R12: With mask bit0 set, dmaReq and status bit4 follow REQ during data phases, and a dmaAck pulse moves one byte. With bit0 clear, dmaReq stays low and dmaAck has no effect.
- R13: With mask bit1 set, irq and status bit5 rise on entry to the completion phase and clear when the completion byte is read.
- R14: A write to port 1 returns the sequencer to idle at once. Status reads 0x00, irq is low, the mask (read on port 3) is 0 and the last error code is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hostAddr | input | 2 | Port select: 0 data, 1 status/reset, 2 select, 3 mask |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWdata | input | 8 | Host write data (also used for DMA writes) |
| hostRdata | output | 8 | Read data for the addressed port, or the data byte during dmaAck |
| dmaReq | output | 1 | Byte transfer request in DMA mode |
| dmaAck | input | 1 | Acknowledge that moves one byte in DMA mode |
| irq | output | 1 | Completion interrupt |

## Verification
Every one of the 256 opcodes is issued, and each opcode outside the defined set must fail with code 0x20 and skip the data phase. This separates opcode decoding from phase sequencing. All 64 sector numbers are tried with zero-count reads, which places the legality edge exactly between 16 and 17. Multi-sector writes and reads use a different byte pattern in each sector, so sector replay and last-sector retention can be told apart. The same transfers are repeated with DMA pacing and with DMA disabled, which separates the two byte-moving paths. A reset in the middle of a transfer and interrupt enable on and off cover the clearing paths.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  parameter int SECTOR_BYTES = 512;
  parameter int SECTORS_PER_TRACK = 17;
  parameter int CMD_BYTES = 6;
  parameter int PARAM_BYTES = 8;
  parameter int SENSE_BYTES = 4;
  localparam int BUF_AW = $clog2(SECTOR_BYTES);
  localparam int TOT_W = 8 + BUF_AW;

  localparam logic [7:0] OP_RECAL = 8'h01;
  localparam logic [7:0] OP_SENSE = 8'h03;
  localparam logic [7:0] OP_READ = 8'h08;
  localparam logic [7:0] OP_WRITE = 8'h0A;
  localparam logic [7:0] OP_SPECIFY = 8'h0C;
  localparam logic [7:0] OP_ECCLEN = 8'h0D;
  localparam logic [7:0] ERR_NONE = 8'h00;
  localparam logic [7:0] ERR_BADCMD = 8'h20;
  localparam logic [7:0] ERR_BADSECT = 8'h21;

  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_DIN, PH_DOUT, PH_STAT} phase_t;
  typedef enum logic [1:0] {SRC_SENSE, SRC_ECC, SRC_BUF} in_src_t;

  typedef struct packed {
    logic       cmdLoad;
    logic       parLoad;
    logic       bufLoad;
    logic       finish;
    logic [7:0] finCode;
    logic       clearAll;
  } dp_strobe_t;
endpackage

// File: rtl/hdc_seq_ctrl.sv
module hdc_seq_ctrl
  import hdc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       hostAddr,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [7:0]       hostWdata,
  input  logic             dmaAck,
  input  logic [7:0]       opcode,
  input  logic [5:0]       secNum,
  input  logic [7:0]       blkCnt,
  output dp_strobe_t       strb,
  output logic [TOT_W-1:0] byteIdx,
  output in_src_t          inSrc,
  output phase_t           phase,
  output logic [7:0]       statusByte,
  output logic [1:0]       maskBits,
  output logic             drqOut,
  output logic             irqOut
);
  logic gap, irqPend, outIsPar, lastByte;
  logic [TOT_W-1:0] total;
  logic dataWr, dataRd, stsWr, selWr, maskWr, dmaOk, req, moveIn, moveOut;
  phase_t planPhase;
  logic [TOT_W-1:0] planTotal;
  in_src_t planSrc;
  logic [7:0] planCode;
  logic planPar;
  logic [5:0] unusedCtl;

  assign unusedCtl = hostWdata[7:2];
  assign dataWr = hostWr && hostAddr == 2'd0;
  assign dataRd = hostRd && hostAddr == 2'd0;
  assign stsWr  = hostWr && hostAddr == 2'd1;
  assign selWr  = hostWr && hostAddr == 2'd2;
  assign maskWr = hostWr && hostAddr == 2'd3;
  assign dmaOk  = maskBits[0] && dmaAck;
  assign req    = phase != PH_IDLE && !gap;
  assign moveIn  = req && ((phase == PH_DIN && (dataRd || dmaOk)) || (phase == PH_STAT && dataRd));
  assign moveOut = req && ((phase == PH_CMD && dataWr) || (phase == PH_DOUT && (dataWr || dmaOk)));
  assign lastByte = byteIdx == total - TOT_W'(1);

  // opcode decode, valid while the sixth command byte is written
  always_comb begin
    planPhase = PH_STAT;
    planTotal = '0;
    planSrc = SRC_SENSE;
    planCode = ERR_NONE;
    planPar = 1'b0;
    unique case (opcode)
      OP_RECAL: ;
      OP_SENSE: begin planPhase = PH_DIN; planTotal = TOT_W'(SENSE_BYTES); end
      OP_ECCLEN: begin planPhase = PH_DIN; planTotal = TOT_W'(1); planSrc = SRC_ECC; end
      OP_SPECIFY: begin planPhase = PH_DOUT; planTotal = TOT_W'(PARAM_BYTES); planPar = 1'b1; end
      OP_READ, OP_WRITE: begin
        if (int'(secNum) >= SECTORS_PER_TRACK) planCode = ERR_BADSECT;
        else if (blkCnt != 8'd0) begin
          planPhase = (opcode == OP_READ) ? PH_DIN : PH_DOUT;
          planTotal = TOT_W'(blkCnt) * TOT_W'(SECTOR_BYTES);
          planSrc = SRC_BUF;
        end
      end
      default: planCode = ERR_BADCMD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE; gap <= 1'b0; maskBits <= '0; irqPend <= 1'b0;
      byteIdx <= '0; total <= '0; inSrc <= SRC_SENSE; outIsPar <= 1'b0;
    end else if (stsWr) begin
      phase <= PH_IDLE; gap <= 1'b0; maskBits <= '0; irqPend <= 1'b0; byteIdx <= '0;
    end else begin
      gap <= moveIn || moveOut;
      if (maskWr) maskBits <= hostWdata[1:0];
      unique case (phase)
        PH_IDLE: if (selWr) begin phase <= PH_CMD; byteIdx <= '0; end
        PH_CMD: if (moveOut) begin
          if (byteIdx == TOT_W'(CMD_BYTES - 1)) begin
            phase <= planPhase; total <= planTotal; inSrc <= planSrc;
            outIsPar <= planPar; byteIdx <= '0;
            if (planPhase == PH_STAT) irqPend <= maskBits[1];
          end else byteIdx <= byteIdx + TOT_W'(1);
        end
        PH_DIN, PH_DOUT: if (moveIn || moveOut) begin
          if (lastByte) begin
            phase <= PH_STAT; byteIdx <= '0; irqPend <= maskBits[1];
          end else byteIdx <= byteIdx + TOT_W'(1);
        end
        PH_STAT: if (moveIn) begin phase <= PH_IDLE; irqPend <= 1'b0; end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    strb.clearAll = stsWr;
    strb.cmdLoad = phase == PH_CMD && moveOut;
    strb.parLoad = phase == PH_DOUT && moveOut && outIsPar;
    strb.bufLoad = phase == PH_DOUT && moveOut && !outIsPar;
    if (phase == PH_CMD && moveOut && byteIdx == TOT_W'(CMD_BYTES - 1) && planPhase == PH_STAT) begin
      strb.finish = 1'b1;
      strb.finCode = planCode;
    end else if ((phase == PH_DIN || phase == PH_DOUT) && (moveIn || moveOut) && lastByte) begin
      strb.finish = 1'b1;
    end
  end

  assign drqOut = maskBits[0] && req && (phase == PH_DIN || phase == PH_DOUT);
  assign irqOut = irqPend;
  assign statusByte = {2'b00, irqPend, drqOut, phase != PH_IDLE,
                       phase == PH_CMD || phase == PH_STAT,
                       phase == PH_DIN || phase == PH_STAT, req};
endmodule

// File: rtl/hdc_seq_datapath.sv
module hdc_seq_datapath
  import hdc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strb,
  input  logic [TOT_W-1:0] byteIdx,
  input  in_src_t          inSrc,
  input  phase_t           phase,
  input  logic [7:0]       hostWdata,
  output logic [7:0]       opcode,
  output logic [5:0]       secNum,
  output logic [7:0]       blkCnt,
  output logic [7:0]       dataByte
);
  logic [7:0] cmdBlk [CMD_BYTES];
  logic [7:0] parReg [PARAM_BYTES];
  logic [7:0] secBuf [SECTOR_BYTES];
  logic [7:0] lastErr;
  logic [7:0] inByte, compByte;
  logic unusedBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CMD_BYTES; i++) cmdBlk[i] <= '0;
      for (int i = 0; i < PARAM_BYTES; i++) parReg[i] <= '0;
      lastErr <= ERR_NONE;
    end else begin
      if (strb.cmdLoad) cmdBlk[byteIdx[2:0]] <= hostWdata;
      if (strb.parLoad) parReg[byteIdx[2:0]] <= hostWdata;
      if (strb.clearAll) lastErr <= ERR_NONE;
      else if (strb.finish) lastErr <= strb.finCode;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.bufLoad) secBuf[byteIdx[BUF_AW-1:0]] <= hostWdata;
  end

  assign opcode = cmdBlk[0];
  assign secNum = cmdBlk[2][5:0];
  assign blkCnt = cmdBlk[4];

  always_comb begin
    unique case (inSrc)
      SRC_SENSE: inByte = (byteIdx == '0) ? lastErr : 8'h00;
      SRC_ECC:   inByte = parReg[PARAM_BYTES-1];
      default:   inByte = secBuf[byteIdx[BUF_AW-1:0]];
    endcase
  end

  assign compByte = {2'b00, cmdBlk[1][5], 3'b000, lastErr != ERR_NONE, 1'b0};
  assign dataByte = (phase == PH_STAT) ? compByte : (phase == PH_DIN) ? inByte : 8'h00;

  assign unusedBits = ^{cmdBlk[1][7:6], cmdBlk[1][4:0], cmdBlk[2][7:6], cmdBlk[3], cmdBlk[5],
                        parReg[0], parReg[1], parReg[2], parReg[3], parReg[4], parReg[5],
                        parReg[6], byteIdx[TOT_W-1:BUF_AW]};
endmodule

// File: rtl/hdc_host_seq.sv
module hdc_host_seq
  import hdc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] hostAddr,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic       dmaReq,
  input  logic       dmaAck,
  output logic       irq
);
  dp_strobe_t strb;
  logic [TOT_W-1:0] byteIdx;
  in_src_t inSrc;
  phase_t phase;
  logic [7:0] statusByte, dataByte, opcode, blkCnt;
  logic [5:0] secNum;
  logic [1:0] maskBits;

  hdc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .dmaAck(dmaAck), .opcode(opcode), .secNum(secNum),
    .blkCnt(blkCnt), .strb(strb), .byteIdx(byteIdx), .inSrc(inSrc), .phase(phase),
    .statusByte(statusByte), .maskBits(maskBits), .drqOut(dmaReq), .irqOut(irq)
  );

  hdc_seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteIdx(byteIdx), .inSrc(inSrc), .phase(phase),
    .hostWdata(hostWdata), .opcode(opcode), .secNum(secNum), .blkCnt(blkCnt),
    .dataByte(dataByte)
  );

  always_comb begin
    if (dmaAck || hostAddr == 2'd0) hostRdata = dataByte;
    else if (hostAddr == 2'd1) hostRdata = statusByte;
    else if (hostAddr == 2'd3) hostRdata = {6'b0, maskBits};
    else hostRdata = 8'h00;
  end
endmodule

// File: rtl/hdc_host_seq_chk.sv
module hdc_host_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] hostAddr,
  input logic       hostWr,
  input logic       hostRd,
  input logic       irq,
  input logic [7:0] statusByte,
  input logic [1:0] maskBits
);
  p_select_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd2 && !statusByte[3]) |=> statusByte[3:0] == 4'hD);

  p_req_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd0 && statusByte[3:0] == 4'hD) |=> !statusByte[0]);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 2'd0 && statusByte[3:0] == 4'hF && !hostWr) |=> !statusByte[3]);

  p_drq_mask_r12: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[4] |-> (maskBits[0] && statusByte[0] && !statusByte[2]));

  p_irq_stat_r13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> statusByte[2:1] == 2'b11);

  p_reset_idle_r14: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd1) |=> (statusByte == 8'h00 && !irq && maskBits == 2'b00));
endmodule

bind hdc_host_seq hdc_host_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
  .irq(irq), .statusByte(statusByte), .maskBits(maskBits)
);

// File: tb/test_hdc_host_seq.sv
module test_hdc_host_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic hostWr = 1'b0, hostRd = 1'b0, dmaAck = 1'b0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic dmaReq, irq;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  hdc_host_seq i_hdc_host_seq (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .dmaReq(dmaReq), .dmaAck(dmaAck), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * 7 + k * 29 + 3) & 255);
  endfunction

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    hostAddr = a; #1; v = hostRdata;
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); hostAddr = a; hostRd = 1'b1; #1; d = hostRdata;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic waitReq;
    logic [7:0] s;
    for (int n = 0; n < 20; n++) begin
      peek(2'd1, s);
      if (s[0]) return;
      @(negedge clk);
    end
  endtask

  task automatic putByte(input logic [7:0] b);
    waitReq(); hwr(2'd0, b);
  endtask

  task automatic getByte(output logic [7:0] b);
    waitReq(); hrd(2'd0, b);
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] hd, input logic [7:0] sc,
                       input logic [7:0] cnt);
    hwr(2'd2, 8'h00);
    putByte(op); putByte(hd); putByte(sc); putByte(8'h12); putByte(cnt); putByte(8'h05);
  endtask

  task automatic finishCmd(input logic [7:0] exp, input string tag);
    logic [7:0] s, b;
    waitReq(); peek(2'd1, s);
    chk({24'd0, s & 8'h0F}, 32'h0F, {tag, " completion phase status"});
    hrd(2'd0, b);
    chk({24'd0, b}, {24'd0, exp}, {tag, " completion byte"});
    peek(2'd1, s);
    chk({24'd0, s}, 32'h00, "R7 idle after completion read");
  endtask

  task automatic senseExpect(input logic [7:0] code, input string tag);
    logic [7:0] s, b;
    issue(8'h03, 8'h00, 8'h00, 8'h00);
    waitReq(); peek(2'd1, s);
    chk({24'd0, s}, 32'h0B, "R5 sense data-in status");
    for (int i = 0; i < 4; i++) begin
      getByte(b);
      chk({24'd0, b}, (i == 0) ? {24'd0, code} : 32'h0, {tag, " sense byte"});
    end
    finishCmd(8'h00, "R8 sense");
  endtask

  task automatic pioWrite(input int nsec, input int k0);
    logic [7:0] s;
    issue(8'h0A, 8'h00, 8'h03, 8'(nsec));
    waitReq(); peek(2'd1, s);
    chk({24'd0, s}, 32'h09, "R5 data-out status");
    for (int k = 0; k < nsec; k++)
      for (int i = 0; i < 512; i++) putByte(pat(i, k0 + k));
    finishCmd(8'h00, "R11 write");
  endtask

  task automatic pioReadCheck(input int nsec, input int k);
    logic [7:0] b;
    issue(8'h08, 8'h20, 8'h05, 8'(nsec));
    for (int j = 0; j < nsec; j++)
      for (int i = 0; i < 512; i++) begin
        getByte(b);
        chk({24'd0, b}, {24'd0, pat(i, k)}, "R11 read data");
      end
    finishCmd(8'h20, "R11 read");
  endtask

  initial begin
    logic [7:0] s, b;
    logic isKnown;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    peek(2'd1, s);
    chk({24'd0, s}, 32'h00, "R1 reset status");
    chk({31'd0, irq}, 0, "R1 reset irq");

    // select and command phase with REQ gap
    hwr(2'd2, 8'h5A);
    peek(2'd1, s);
    chk({24'd0, s}, 32'h0D, "R2 command phase status");
    hwr(2'd0, 8'h01);
    peek(2'd1, s);
    chk({24'd0, s}, 32'h0C, "R4 REQ low after byte");
    @(negedge clk); peek(2'd1, s);
    chk({24'd0, s}, 32'h0D, "R4 REQ back");
    putByte(8'h20); putByte(8'h00); putByte(8'h00); putByte(8'h00); putByte(8'h00);
    peek(2'd1, s);
    chk({24'd0, s}, 32'h0E, "R3 phase after sixth byte, REQ gap");
    finishCmd(8'h20, "R6 recalibrate R11");

    // sweep of all opcodes outside the defined set
    for (int op = 0; op < 256; op++) begin
      isKnown = (op == 1 || op == 3 || op == 8 || op == 10 || op == 12 || op == 13);
      if (!isKnown) begin
        issue(8'(op), 8'((op & 1) << 5), 8'h01, 8'h01);
        finishCmd(8'(((op & 1) << 5) | 2), "R9 unknown opcode");
        senseExpect(8'h20, "R9 R8 error code");
        if (op % 37 == 0) senseExpect(8'h00, "R8 cleared by sense");
      end
    end

    // specify then ECC length
    for (int r = 0; r < 2; r++) begin
      issue(8'h0C, 8'h00, 8'h00, 8'h00);
      waitReq(); peek(2'd1, s);
      chk({24'd0, s}, 32'h09, "R5 specify data-out");
      for (int i = 0; i < 8; i++) putByte((i == 7) ? 8'(11 + 40 * r) : 8'(16 + i));
      finishCmd(8'h00, "R10 specify");
      issue(8'h0D, 8'h00, 8'h00, 8'h00);
      getByte(b);
      chk({24'd0, b}, 32'(11 + 40 * r), "R10 ECC length byte");
      finishCmd(8'h00, "R10 ecc");
    end

    // sector number sweep with zero-count reads
    for (int sn = 0; sn < 64; sn++) begin
      issue(8'h08, 8'h00, 8'(8'hC0 | sn), 8'h00);
      finishCmd((sn < 17) ? 8'h00 : 8'h02, "R11 sector range");
      senseExpect((sn < 17) ? 8'h00 : 8'h21, "R11 sector error code");
    end

    // programmed transfers
    pioWrite(1, 0);
    pioReadCheck(2, 0);
    pioWrite(2, 1);
    pioReadCheck(1, 2);

    // DMA paced read and write
    hwr(2'd3, 8'h01);
    peek(2'd3, s);
    chk({24'd0, s}, 32'h01, "R12 mask readback");
    issue(8'h08, 8'h00, 8'h00, 8'h01);
    for (int i = 0; i < 512; i++) begin
      for (int n = 0; n < 10 && !dmaReq; n++) @(negedge clk);
      chk({31'd0, dmaReq}, 1, "R12 dmaReq in data-in");
      if (i == 0) begin peek(2'd1, s); chk({24'd0, s}, 32'h1B, "R12 DRQ status bit"); end
      dmaAck = 1'b1; #1; b = hostRdata;
      @(negedge clk); dmaAck = 1'b0;
      chk({24'd0, b}, {24'd0, pat(i, 2)}, "R12 DMA read data");
      if (i == 0) chk({31'd0, dmaReq}, 0, "R12 R4 dmaReq gap");
    end
    finishCmd(8'h00, "R12 dma read");
    issue(8'h0A, 8'h00, 8'h00, 8'h01);
    for (int i = 0; i < 512; i++) begin
      for (int n = 0; n < 10 && !dmaReq; n++) @(negedge clk);
      dmaAck = 1'b1; hostWdata = pat(i, 5);
      @(negedge clk); dmaAck = 1'b0;
    end
    finishCmd(8'h00, "R12 dma write");
    hwr(2'd3, 8'h00);
    pioReadCheck(1, 5);

    // dmaAck ignored when disabled
    issue(8'h08, 8'h00, 8'h00, 8'h01);
    waitReq();
    chk({31'd0, dmaReq}, 0, "R12 no dmaReq when disabled");
    dmaAck = 1'b1; @(negedge clk); dmaAck = 1'b0;
    for (int i = 0; i < 512; i++) begin
      getByte(b);
      chk({24'd0, b}, {24'd0, pat(i, 5)}, "R12 dmaAck ignored, data order kept");
    end
    finishCmd(8'h00, "R12 disabled read");

    // completion interrupt
    hwr(2'd3, 8'h02);
    issue(8'h01, 8'h00, 8'h00, 8'h00);
    waitReq(); peek(2'd1, s);
    chk({31'd0, irq}, 1, "R13 irq at completion");
    chk({24'd0, s}, 32'h2F, "R13 IRQ status bit");
    finishCmd(8'h00, "R13 recal");
    chk({31'd0, irq}, 0, "R13 irq cleared");
    hwr(2'd3, 8'h00);
    issue(8'h01, 8'h00, 8'h00, 8'h00);
    waitReq();
    chk({31'd0, irq}, 0, "R13 irq disabled");
    finishCmd(8'h00, "R13 recal no irq");

    // reset mid-transfer
    issue(8'h77, 8'h00, 8'h00, 8'h00);
    finishCmd(8'h02, "R9 before reset");
    hwr(2'd3, 8'h03);
    issue(8'h08, 8'h00, 8'h00, 8'h01);
    getByte(b); getByte(b);
    hwr(2'd1, 8'h00);
    peek(2'd1, s);
    chk({24'd0, s}, 32'h00, "R14 status after reset");
    chk({31'd0, irq}, 0, "R14 irq after reset");
    peek(2'd3, s);
    chk({24'd0, s}, 32'h00, "R14 mask after reset");
    senseExpect(8'h00, "R14 error code cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule